// File: doc/BRIEF.md
# PLL Retune Register Sequencer

This block updates the feedback divider word and the power-of-two post-divider of a PLL through its control registers in an order that cannot glitch the loop. A start pulse delivers the new divider word and post-divider exponent. The sequencer then performs a fixed series of read-modify-write operations on a shadow copy of the PLL control registers. First the fine-tuner is disabled. Next the post-divider field and the divider word are written, and a change request is raised. After that the tuner word is loaded and the tuner is enabled again. Last, a settle interval is counted before completion is reported.

Every register write also appears on a one-write-per-cycle output stream, so the chip can forward it to the analog macro. The full register image is exposed as well. Field positions are parameters, as are register sharing (post-divider and divider word in one register), the presence of a tuner register, the location of the tuner enable and the settle length. The parameters are computed elsewhere.

Top module: `pll_retune_seq`

## Requirements
- R1: The first write of every operation clears the tuner enable. No write to the post-divider or divider-word register happens while the tuner enable is set. The last write of the operation sets the tuner enable again.
- R2: The post-divider field is 3 bits wide at bit POSTDIV_LSB and receives the exponent of the divider (divide by 2^exp). All other bits of that register keep their previous value.
- R3: Write addresses are coded 0 post-divider, 1 divider word, 2 change, 3 tuner, 4 tuner enable. With separate registers, address 0 is written before address 1. With a shared register, one write to address 1 carries both fields, and address 0 is never written.
- R4: The divider word goes to the PCW_W-bit field at bit DIVWORD_LSB, and the other bits are preserved. The next write sets bit 31 of the change register and leaves its other bits unchanged.
- R5: When a tuner register exists, it is written with the newly written divider-word register value plus one.
- R6: The tuner enable is bit TUNER_EN_BIT of a dedicated register when one exists. Otherwise it is bit 31 of the tuner register.
- R7: busy rises in the cycle after an accepted start and stays high through the done cycle. done is a one-cycle pulse that comes SETTLE_CYCLES+1 cycles after the cycle of the tuner-enable restore write.
- R8: A start while busy is high, including the done cycle, is ignored. It causes no writes and changes no register.
- R9: After reset, every register holds its parameter initial value, and busy, done and wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to apply new parameters |
| pcw_in | input | PCW_W | New feedback divider word |
| post_exp_in | input | 3 | Post-divider exponent |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register written (see R3) |
| wr_data | output | 32 | Value written |
| postdiv_reg | output | 32 | Post-divider register image |
| divword_reg | output | 32 | Divider-word register image |
| change_reg | output | 32 | Change register image |
| tuner_reg | output | 32 | Tuner register image |
| tuner_en_reg | output | 32 | Tuner enable register image |

## Verification
Two events can meet in the same cycle: completion (the done pulse) and a new start request. The bench raises start exactly in a cycle where done is high, and also in the middle of an operation. It then judges from the write stream that neither request started a new series of writes, and that busy falls right after done. The write order and data are also compared against an independently kept register model, both for separate registers with a dedicated tuner-enable register and for a shared register with the enable held inside the tuner register.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

    localparam int REG_W          = 32;
    localparam int POSTDIV_W      = 3;
    localparam int CHG_REQ_BIT    = 31;
    localparam int INLINE_EN_BIT  = 31;

    typedef enum logic [2:0] {
        RG_POSTDIV  = 3'd0,
        RG_DIVWORD  = 3'd1,
        RG_CHANGE   = 3'd2,
        RG_TUNER    = 3'd3,
        RG_TUNER_EN = 3'd4
    } reg_id_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TUNER_OFF,
        ST_POSTDIV,
        ST_DIVWORD,
        ST_CHANGE,
        ST_TUNER_LOAD,
        ST_TUNER_ON,
        ST_SETTLE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic             en;
        reg_id_e          id;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic [REG_W-1:0] postdiv;
        logic [REG_W-1:0] divword;
        logic [REG_W-1:0] change;
        logic [REG_W-1:0] tuner;
        logic [REG_W-1:0] tuner_en;
    } reg_image_t;

    function automatic logic [REG_W-1:0] field_mask(input int lsb, input int width);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= lsb && i < lsb + width) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] put_field(input logic [REG_W-1:0] word,
                                                   input logic [REG_W-1:0] val,
                                                   input int lsb, input int width);
        logic [REG_W-1:0] m;
        m = field_mask(lsb, width);
        return (word & ~m) | ((val << lsb) & m);
    endfunction

    function automatic logic [REG_W-1:0] bit_at(input int pos);
        return REG_W'(1) << pos;
    endfunction

endpackage

// File: rtl/pll_retune_settle.sv
module pll_retune_settle #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);

    AST_SETTLE_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);  // R7
    AST_SETTLE_FULL: assert property (@(posedge clk) disable iff (rst)
        expire |-> run && (CYCLES == 1 || $past(run)));  // R7
endmodule

// File: rtl/pll_retune_regs.sv
module pll_retune_regs import pll_retune_pkg::*; #(
    parameter int               POSTDIV_LSB  = 24,
    parameter bit               HAS_TEN_REG  = 1'b1,
    parameter bit               HAS_TUNER    = 1'b1,
    parameter int               TUNER_EN_BIT = 5,
    parameter logic [REG_W-1:0] PD_INIT      = '0,
    parameter logic [REG_W-1:0] PCW_INIT     = '0,
    parameter logic [REG_W-1:0] CHG_INIT     = '0,
    parameter logic [REG_W-1:0] TUN_INIT     = '0,
    parameter logic [REG_W-1:0] TEN_INIT     = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  reg_wr_t    wr,
    output reg_image_t img
);
    localparam logic [REG_W-1:0] PD_MASK = field_mask(POSTDIV_LSB, POSTDIV_W);

    always_ff @(posedge clk) begin
        if (rst) begin
            img.postdiv  <= PD_INIT;
            img.divword  <= PCW_INIT;
            img.change   <= CHG_INIT;
            img.tuner    <= TUN_INIT;
            img.tuner_en <= TEN_INIT;
        end else if (wr.en) begin
            case (wr.id)
                RG_POSTDIV:  img.postdiv  <= wr.data;
                RG_DIVWORD:  img.divword  <= wr.data;
                RG_CHANGE:   img.change   <= wr.data;
                RG_TUNER:    img.tuner    <= wr.data;
                RG_TUNER_EN: img.tuner_en <= wr.data;
                default: ;
            endcase
        end
    end

    logic tuner_live;
    assign tuner_live = HAS_TEN_REG ? img.tuner_en[TUNER_EN_BIT]
                      : (HAS_TUNER ? img.tuner[INLINE_EN_BIT] : 1'b0);

    AST_TUNER_GATED: assert property (@(posedge clk) disable iff (rst)
        wr.en && (wr.id == RG_POSTDIV || wr.id == RG_DIVWORD) |-> !tuner_live);  // R1
    AST_PD_KEEP_OTHER: assert property (@(posedge clk) disable iff (rst)
        wr.en && wr.id == RG_POSTDIV |-> ((wr.data ^ img.postdiv) & ~PD_MASK) == '0);  // R2
    AST_CHG_KEEP_OTHER: assert property (@(posedge clk) disable iff (rst)
        wr.en && wr.id == RG_CHANGE |-> wr.data[CHG_REQ_BIT] &&
        ((wr.data ^ img.change) & ~bit_at(CHG_REQ_BIT)) == '0);  // R4
    AST_TUNER_PLUS_ONE: assert property (@(posedge clk) disable iff (rst)
        wr.en && wr.id == RG_TUNER && $past(wr.en && wr.id == RG_CHANGE)
        |-> wr.data == img.divword + 32'd1);  // R5
endmodule

// File: rtl/pll_retune_fsm.sv
module pll_retune_fsm import pll_retune_pkg::*; #(
    parameter int PCW_W         = 22,
    parameter int DIVWORD_LSB   = 0,
    parameter int POSTDIV_LSB   = 24,
    parameter bit SHARED_PD_PCW = 1'b0,
    parameter bit HAS_TUNER     = 1'b1,
    parameter bit HAS_TEN_REG   = 1'b1,
    parameter int TUNER_EN_BIT  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PCW_W-1:0] pcw_in,
    input  logic [2:0]       post_exp_in,
    input  reg_image_t       img,
    input  logic             settle_expire,
    output seq_state_e       state,
    output reg_wr_t          wr
);
    localparam int TUNER_CTRL = HAS_TEN_REG ? 2 : (HAS_TUNER ? 1 : 0);

    seq_state_e       nxt;
    logic [PCW_W-1:0] pcw_q;
    logic [2:0]       exp_q;
    logic             accept;

    assign accept = (state == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pcw_q <= '0;
            exp_q <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                pcw_q <= pcw_in;
                exp_q <= post_exp_in;
            end
        end
    end

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:       if (start) nxt = ST_TUNER_OFF;
            ST_TUNER_OFF:  nxt = ST_POSTDIV;
            ST_POSTDIV:    nxt = ST_DIVWORD;
            ST_DIVWORD:    nxt = ST_CHANGE;
            ST_CHANGE:     nxt = ST_TUNER_LOAD;
            ST_TUNER_LOAD: nxt = ST_TUNER_ON;
            ST_TUNER_ON:   nxt = ST_SETTLE;
            ST_SETTLE:     if (settle_expire) nxt = ST_DONE;
            ST_DONE:       nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    logic [REG_W-1:0] pd_word;
    logic [REG_W-1:0] pcw_base;
    logic [REG_W-1:0] pcw_word;

    assign pd_word  = put_field(img.postdiv, REG_W'(exp_q), POSTDIV_LSB, POSTDIV_W);
    assign pcw_base = SHARED_PD_PCW ? put_field(img.divword, REG_W'(exp_q), POSTDIV_LSB, POSTDIV_W)
                                    : img.divword;
    assign pcw_word = put_field(pcw_base, REG_W'(pcw_q), DIVWORD_LSB, PCW_W);

    always_comb begin
        wr.en   = 1'b0;
        wr.id   = RG_POSTDIV;
        wr.data = '0;
        case (state)
            ST_TUNER_OFF: begin
                if (TUNER_CTRL == 2) begin
                    wr.en   = 1'b1;
                    wr.id   = RG_TUNER_EN;
                    wr.data = img.tuner_en & ~bit_at(TUNER_EN_BIT);
                end else if (TUNER_CTRL == 1) begin
                    wr.en   = 1'b1;
                    wr.id   = RG_TUNER;
                    wr.data = img.tuner & ~bit_at(INLINE_EN_BIT);
                end
            end
            ST_POSTDIV: begin
                if (!SHARED_PD_PCW) begin
                    wr.en   = 1'b1;
                    wr.id   = RG_POSTDIV;
                    wr.data = pd_word;
                end
            end
            ST_DIVWORD: begin
                wr.en   = 1'b1;
                wr.id   = RG_DIVWORD;
                wr.data = pcw_word;
            end
            ST_CHANGE: begin
                wr.en   = 1'b1;
                wr.id   = RG_CHANGE;
                wr.data = img.change | bit_at(CHG_REQ_BIT);
            end
            ST_TUNER_LOAD: begin
                if (HAS_TUNER) begin
                    wr.en   = 1'b1;
                    wr.id   = RG_TUNER;
                    wr.data = img.divword + 32'd1;
                end
            end
            ST_TUNER_ON: begin
                if (TUNER_CTRL == 2) begin
                    wr.en   = 1'b1;
                    wr.id   = RG_TUNER_EN;
                    wr.data = img.tuner_en | bit_at(TUNER_EN_BIT);
                end else if (TUNER_CTRL == 1) begin
                    wr.en   = 1'b1;
                    wr.id   = RG_TUNER;
                    wr.data = img.tuner | bit_at(INLINE_EN_BIT);
                end
            end
            default: ;
        endcase
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_SETTLE || state == ST_DONE) |-> !wr.en);  // R8
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(pcw_q) && $stable(exp_q));  // R8
    AST_CHG_AFTER_PCW: assert property (@(posedge clk) disable iff (rst)
        wr.en && wr.id == RG_CHANGE |-> $past(wr.en && wr.id == RG_DIVWORD));  // R4
    AST_SHARED_NO_PD: assert property (@(posedge clk) disable iff (rst)
        SHARED_PD_PCW && wr.en |-> wr.id != RG_POSTDIV);  // R3
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq import pll_retune_pkg::*; #(
    parameter int          PCW_W         = 22,
    parameter int          DIVWORD_LSB   = 0,
    parameter int          POSTDIV_LSB   = 24,
    parameter bit          SHARED_PD_PCW = 1'b0,
    parameter bit          HAS_TUNER     = 1'b1,
    parameter bit          HAS_TEN_REG   = 1'b1,
    parameter int          TUNER_EN_BIT  = 5,
    parameter int          SETTLE_CYCLES = 1000,
    parameter logic [31:0] PD_INIT       = 32'hA5A5_A5A5,
    parameter logic [31:0] PCW_INIT      = 32'h8000_0000,
    parameter logic [31:0] CHG_INIT      = 32'h0000_0001,
    parameter logic [31:0] TUN_INIT      = 32'h0000_0000,
    parameter logic [31:0] TEN_INIT      = 32'h0000_0020
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PCW_W-1:0] pcw_in,
    input  logic [2:0]       post_exp_in,
    output logic             busy,
    output logic             done,
    output logic             wr_en,
    output logic [2:0]       wr_addr,
    output logic [31:0]      wr_data,
    output logic [31:0]      postdiv_reg,
    output logic [31:0]      divword_reg,
    output logic [31:0]      change_reg,
    output logic [31:0]      tuner_reg,
    output logic [31:0]      tuner_en_reg
);
    seq_state_e state;
    reg_wr_t    wr;
    reg_image_t img;
    logic       settle_expire;

    pll_retune_fsm #(
        .PCW_W(PCW_W), .DIVWORD_LSB(DIVWORD_LSB), .POSTDIV_LSB(POSTDIV_LSB),
        .SHARED_PD_PCW(SHARED_PD_PCW), .HAS_TUNER(HAS_TUNER),
        .HAS_TEN_REG(HAS_TEN_REG), .TUNER_EN_BIT(TUNER_EN_BIT)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .pcw_in(pcw_in),
        .post_exp_in(post_exp_in), .img(img), .settle_expire(settle_expire),
        .state(state), .wr(wr)
    );

    pll_retune_regs #(
        .POSTDIV_LSB(POSTDIV_LSB), .HAS_TEN_REG(HAS_TEN_REG), .HAS_TUNER(HAS_TUNER),
        .TUNER_EN_BIT(TUNER_EN_BIT), .PD_INIT(PD_INIT), .PCW_INIT(PCW_INIT),
        .CHG_INIT(CHG_INIT), .TUN_INIT(TUN_INIT), .TEN_INIT(TEN_INIT)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .img(img)
    );

    pll_retune_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst(rst), .run(state == ST_SETTLE), .expire(settle_expire)
    );

    assign busy         = (state != ST_IDLE);
    assign done         = (state == ST_DONE);
    assign wr_en        = wr.en;
    assign wr_addr      = wr.id;
    assign wr_data      = wr.data;
    assign postdiv_reg  = img.postdiv;
    assign divword_reg  = img.divword;
    assign change_reg   = img.change;
    assign tuner_reg    = img.tuner;
    assign tuner_en_reg = img.tuner_en;

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && !done);  // R8
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> busy && !done);  // R7
endmodule

// File: tb/pll_retune_seq_bench.sv
module pll_retune_seq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;

    // instance A: separate registers, dedicated tuner-enable register
    logic        a_start = 1'b0;
    logic [21:0] a_pcw   = '0;
    logic [2:0]  a_exp   = '0;
    logic        a_busy, a_done, a_wr_en;
    logic [2:0]  a_wr_addr;
    logic [31:0] a_wr_data, a_pd, a_pcwr, a_chg, a_tun, a_ten;

    pll_retune_seq u_pll_retune_seq (
        .clk(clk), .rst(rst), .start(a_start), .pcw_in(a_pcw), .post_exp_in(a_exp),
        .busy(a_busy), .done(a_done), .wr_en(a_wr_en), .wr_addr(a_wr_addr),
        .wr_data(a_wr_data), .postdiv_reg(a_pd), .divword_reg(a_pcwr),
        .change_reg(a_chg), .tuner_reg(a_tun), .tuner_en_reg(a_ten)
    );

    // instance B: shared register, enable inside tuner register
    logic        b_start = 1'b0;
    logic [19:0] b_pcw   = '0;
    logic [2:0]  b_exp   = '0;
    logic        b_busy, b_done, b_wr_en;
    logic [2:0]  b_wr_addr;
    logic [31:0] b_wr_data, b_pd, b_pcwr, b_chg, b_tun, b_ten;

    pll_retune_seq #(
        .PCW_W(20), .DIVWORD_LSB(4), .POSTDIV_LSB(28), .SHARED_PD_PCW(1'b1),
        .HAS_TUNER(1'b1), .HAS_TEN_REG(1'b0), .TUNER_EN_BIT(0), .SETTLE_CYCLES(8),
        .PD_INIT(32'h0), .PCW_INIT(32'h0000_000F), .CHG_INIT(32'h0),
        .TUN_INIT(32'h8000_0000), .TEN_INIT(32'h0)
    ) u_pll_retune_seq_shared (
        .clk(clk), .rst(rst), .start(b_start), .pcw_in(b_pcw), .post_exp_in(b_exp),
        .busy(b_busy), .done(b_done), .wr_en(b_wr_en), .wr_addr(b_wr_addr),
        .wr_data(b_wr_data), .postdiv_reg(b_pd), .divword_reg(b_pcwr),
        .change_reg(b_chg), .tuner_reg(b_tun), .tuner_en_reg(b_ten)
    );

    // write-stream loggers, sampled at the falling edge
    int          na = 0, nda = 0, nb = 0, ndb = 0;
    logic [2:0]  la_id [0:127];
    logic [31:0] la_dt [0:127];
    int          la_cy [0:127];
    int          a_dcy = 0;
    logic [2:0]  lb_id [0:127];
    logic [31:0] lb_dt [0:127];
    int          lb_cy [0:127];
    int          b_dcy = 0;

    always @(negedge clk) begin
        if (!rst && a_wr_en) begin
            la_id[na % 128] = a_wr_addr;
            la_dt[na % 128] = a_wr_data;
            la_cy[na % 128] = cyc;
            na = na + 1;
        end
        if (!rst && a_done) begin a_dcy = cyc; nda = nda + 1; end
        if (!rst && b_wr_en) begin
            lb_id[nb % 128] = b_wr_addr;
            lb_dt[nb % 128] = b_wr_data;
            lb_cy[nb % 128] = cyc;
            nb = nb + 1;
        end
        if (!rst && b_done) begin b_dcy = cyc; ndb = ndb + 1; end
    end

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // independent register models
    logic [31:0] ma_pd  = 32'hA5A5_A5A5;
    logic [31:0] ma_pcw = 32'h8000_0000;
    logic [31:0] ma_chg = 32'h0000_0001;
    logic [31:0] ma_tun = 32'h0000_0000;
    logic [31:0] ma_ten = 32'h0000_0020;
    logic [31:0] mb_pcw = 32'h0000_000F;
    logic [31:0] mb_chg = 32'h0;
    logic [31:0] mb_tun = 32'h8000_0000;

    // intrude: 0 none, 1 start in mid-operation, 2 start in the done cycle
    task automatic run_a(input logic [21:0] pcw, input logic [2:0] ex, input int intrude);
        int base, db;
        logic [31:0] e_dt [0:5];
        logic [2:0]  e_id [0:5];
        string       tag [0:5];
        base = na; db = nda;
        a_pcw = pcw; a_exp = ex; a_start = 1'b1;
        tick;
        a_start = 1'b0;
        chk(a_busy == 1'b1, "R7", "busy after start", 32'(a_busy), 32'd1);
        if (intrude == 1) begin
            repeat (2) tick;
            a_pcw = ~pcw; a_exp = ~ex; a_start = 1'b1;
            tick;
            a_start = 1'b0;
        end
        while (nda == db) tick;
        if (intrude == 2) begin
            a_pcw = pcw ^ 22'h1; a_start = 1'b1;
            tick;
            a_start = 1'b0;
        end else begin
            tick;
        end
        chk(!a_busy && !a_done, "R7", "busy/done after done", {30'd0, a_busy, a_done}, 32'd0);
        repeat (3) tick;
        chk(na - base == 6, "R8", "write count", 32'(na - base), 32'd6);

        e_id[0] = 3'd4; e_dt[0] = ma_ten & ~32'h20;                                   tag[0] = "R1";
        e_id[1] = 3'd0; e_dt[1] = (ma_pd & ~32'h0700_0000) | (32'(ex) << 24);         tag[1] = "R2";
        e_id[2] = 3'd1; e_dt[2] = (ma_pcw & ~32'h003F_FFFF) | 32'(pcw);               tag[2] = "R4";
        e_id[3] = 3'd2; e_dt[3] = ma_chg | 32'h8000_0000;                             tag[3] = "R4";
        e_id[4] = 3'd3; e_dt[4] = e_dt[2] + 32'd1;                                    tag[4] = "R5";
        e_id[5] = 3'd4; e_dt[5] = e_dt[0] | 32'h20;                                   tag[5] = "R6";
        for (int i = 0; i < 6; i++) begin
            chk(la_id[(base + i) % 128] == e_id[i], "R3", "write address",
                32'(la_id[(base + i) % 128]), 32'(e_id[i]));
            chk(la_dt[(base + i) % 128] == e_dt[i], tag[i], "write data",
                la_dt[(base + i) % 128], e_dt[i]);
        end
        chk(a_dcy - la_cy[(base + 5) % 128] == 1001, "R7", "settle length",
            32'(a_dcy - la_cy[(base + 5) % 128]), 32'd1001);
        ma_ten = e_dt[5]; ma_pd = e_dt[1]; ma_pcw = e_dt[2]; ma_chg = e_dt[3]; ma_tun = e_dt[4];
        chk(a_pd == ma_pd, "R2", "postdiv register", a_pd, ma_pd);
        chk(a_pcwr == ma_pcw, "R8", "divider register", a_pcwr, ma_pcw);
        chk(a_tun == ma_tun && a_ten == ma_ten, "R6", "tuner registers", a_ten, ma_ten);
    endtask

    task automatic run_b(input logic [19:0] pcw, input logic [2:0] ex);
        int base, db;
        logic [31:0] e_dt [0:4];
        logic [2:0]  e_id [0:4];
        string       tag [0:4];
        base = nb; db = ndb;
        b_pcw = pcw; b_exp = ex; b_start = 1'b1;
        tick;
        b_start = 1'b0;
        while (ndb == db) tick;
        repeat (3) tick;
        chk(nb - base == 5, "R3", "shared write count", 32'(nb - base), 32'd5);
        e_id[0] = 3'd3; e_dt[0] = mb_tun & ~32'h8000_0000;                            tag[0] = "R6";
        e_id[1] = 3'd1; e_dt[1] = (mb_pcw & ~32'h7000_0000 & ~32'h00FF_FFF0)
                                  | (32'(ex) << 28) | (32'(pcw) << 4);                tag[1] = "R3";
        e_id[2] = 3'd2; e_dt[2] = mb_chg | 32'h8000_0000;                             tag[2] = "R4";
        e_id[3] = 3'd3; e_dt[3] = e_dt[1] + 32'd1;                                    tag[3] = "R5";
        e_id[4] = 3'd3; e_dt[4] = e_dt[3] | 32'h8000_0000;                            tag[4] = "R6";
        for (int i = 0; i < 5; i++) begin
            chk(lb_id[(base + i) % 128] == e_id[i], "R3", "shared address",
                32'(lb_id[(base + i) % 128]), 32'(e_id[i]));
            chk(lb_dt[(base + i) % 128] == e_dt[i], tag[i], "shared data",
                lb_dt[(base + i) % 128], e_dt[i]);
        end
        chk(b_dcy - lb_cy[(base + 4) % 128] == 9, "R7", "shared settle length",
            32'(b_dcy - lb_cy[(base + 4) % 128]), 32'd9);
        mb_pcw = e_dt[1]; mb_chg = e_dt[2]; mb_tun = e_dt[4];
        chk(b_pd == 32'h0, "R3", "shared postdiv register untouched", b_pd, 32'h0);
    endtask

    // {exponent, divider word}
    localparam logic [24:0] VEC_A [0:3] = '{
        {3'd0, 22'h00_0001},
        {3'd7, 22'h3F_FFFF},
        {3'd3, 22'h01_2345},
        {3'd1, 22'h20_0000}
    };

    initial begin
        repeat (3) tick;
        rst = 1'b0;
        tick;
        // R9 reset state
        chk(!a_busy && !a_done && !a_wr_en, "R9", "controls after reset",
            {29'd0, a_busy, a_done, a_wr_en}, 32'd0);
        chk(a_pd == 32'hA5A5_A5A5 && a_pcwr == 32'h8000_0000, "R9", "divider regs after reset",
            a_pd, 32'hA5A5_A5A5);
        chk(a_chg == 32'h1 && a_tun == 32'h0 && a_ten == 32'h20, "R9", "other regs after reset",
            a_ten, 32'h20);

        for (int i = 0; i < 4; i++) run_a(VEC_A[i][21:0], VEC_A[i][24:22], 0);

        run_a(22'h0A_BCDE, 3'd2, 1);   // R8 start in mid-operation
        run_a(22'h15_5555, 3'd5, 2);   // R8 start in the done cycle

        run_b(20'hF_FFFF, 3'd6);
        run_b(20'h0_0300, 3'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R7 watchdog: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule